// File: doc/BRIEF.md
# External Interrupt Controller with Claim and Complete

This block collects level-high or rising-edge requests from 31 external sources, numbered 1 to 31, and presents them to two hart contexts. Each context gets one request line. Software sets the block up through a plain 32-bit register bus. Each source has a 3-bit priority. Each context has an enable bitmap over the sources and a 3-bit threshold. A context's request line rises when at least one source is pending, enabled for that context, and has a priority strictly above that context's threshold.

A handler takes an interrupt by reading its context's claim register. The read returns the ID of the best eligible source and removes that source's pending state. The handler finishes by writing the same ID back to the claim register. Until that write-back arrives, the source's gateway does not forward a new request. Sources 16 to 31 are edge-triggered and sources 1 to 15 are level-triggered. The parameter `EDGE_MASK` sets this split.

Reads return their data on `bus_rdata` one clock after the cycle in which `bus_ren` is sampled high. A claim takes effect in that same clock edge.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every priority, enable word and threshold reads as 0, both request outputs are low, and a claim read returns 0.
- R2: The priority of source n is at byte address 4*n and holds 3 bits, so a written value reads back masked to 3 bits. Address 0 (source 0) always reads 0 and ignores writes.
- R3: The enable word of context c is at 0x2000 + c*0x80. Bit n enables source n. Bit 0 reads 0 whatever is written.
- R4: The threshold of context c is at 0x200000 + c*0x1000 and holds 3 bits. The claim/complete register of context c is at 0x200004 + c*0x1000.
- R5: `irq_o[c]` is high exactly when some source is pending, enabled in context c, and has a priority strictly greater than the threshold of context c. A threshold of 7 keeps `irq_o[c]` low.
- R6: A claim read returns the ID of the eligible source with the highest priority. Ties go to the lowest ID. The read returns 0 when no source is eligible.
- R7: A claim read clears the pending state of the returned source and marks it claimed. A claimed source cannot raise any request line.
- R8: Writing the ID of a claimed source to the claim register of a context that has that source enabled releases the source. A level source whose input is still high becomes pending again.
- R9: A completion write is ignored when its ID is not claimed, or when the source is not enabled in the writing context. The source then stays claimed.
- R10: For a level source, a high input sets pending. Pending stays set after the input falls, until the source is claimed.
- R11: For an edge source, a rising edge sets pending once. Edges that arrive while the source is already pending or claimed are dropped, and an input held high does not request again after completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 22 | Byte address of the register access |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read strobe; a read of a claim register claims a source |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| src_i | input | 31 | Source inputs, bit n is source n |
| irq_o | output | 2 | Request line for each context |

## Verification
The assertions rely on the bus carrying at most one access per cycle, never a read and a write together, so that one clock edge holds a single claim or a single completion. They also rely on word-aligned addresses and on source inputs that are already synchronous to `clk`. The bench drives every strobe and source input on the falling edge, raises one bus strobe at a time and drops it after one cycle, and only uses aligned addresses taken from the register map in the requirements.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int ADDR_W = 22;

  // Register map anchors (byte addresses)
  localparam logic [ADDR_W-1:0] EN_BASE     = 22'h00_2000;
  localparam logic [ADDR_W-1:0] EN_STRIDE   = 22'h00_0080;
  localparam logic [ADDR_W-1:0] PAGE_BASE   = 22'h20_0000;
  localparam logic [ADDR_W-1:0] PAGE_STRIDE = 22'h00_1000;
  localparam logic [9:0]        THR_WORD    = 10'd0;
  localparam logic [9:0]        CLAIM_WORD  = 10'd1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PRIO,
    SEL_EN,
    SEL_THR,
    SEL_CLAIM
  } acc_sel_e;
endpackage

// File: rtl/eic_gateway.sv
module eic_gateway #(
  parameter bit EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic take,
  input  logic done,
  output logic pend,
  output logic claimed
);
  logic trig;
  logic pend_q, pend_d;
  logic cl_q, cl_d;

  generate
    if (EDGE) begin : g_edge
      logic src_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= src;
      end
      assign trig = src & ~src_q;
    end else begin : g_level
      assign trig = src;
    end
  endgenerate

  always_comb begin
    pend_d = pend_q;
    cl_d   = cl_q;
    if (take) begin
      pend_d = 1'b0;
      cl_d   = 1'b1;
    end else begin
      if (done) cl_d = 1'b0;
      if (trig && !cl_q) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cl_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      cl_q   <= cl_d;
    end
  end

  assign pend    = pend_q;
  assign claimed = cl_q;
endmodule

// File: rtl/eic_arbiter.sv
module eic_arbiter #(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 3,
  localparam int ID_W   = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC:1]             pend,
  input  logic [NUM_SRC:1]             en,
  input  logic [NUM_SRC:1][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]            thr,
  output logic                         req,
  output logic [ID_W-1:0]              win_id
);
  logic [PRIO_W-1:0] best;

  // Ascending scan with strict compare: equal priority keeps the lower ID
  always_comb begin
    req    = 1'b0;
    win_id = '0;
    best   = '0;
    for (int n = 1; n <= NUM_SRC; n++) begin
      if (pend[n] && en[n] && (prio[n] > thr)) begin
        if (!req || (prio[n] > best)) begin
          req    = 1'b1;
          win_id = ID_W'(n);
          best   = prio[n];
        end
      end
    end
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eic_pkg::*;
#(
  parameter int          NUM_SRC   = 31,
  parameter int          NUM_CTX   = 2,
  parameter int          PRIO_W    = 3,
  parameter logic [31:0] EDGE_MASK = 32'hFFFF_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wen,
  input  logic [31:0]         bus_wdata,
  input  logic                bus_ren,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_SRC:1]    src_i,
  output logic [NUM_CTX-1:0]  irq_o
);
  localparam int ID_W  = $clog2(NUM_SRC + 1);
  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
  localparam logic [ADDR_W-1:0] PRIO_SPAN = ADDR_W'(4 * (NUM_SRC + 1));
  localparam logic [ADDR_W-1:0] EN_SPAN   = ADDR_W'(NUM_CTX * 128);
  localparam logic [ADDR_W-1:0] PG_SPAN   = ADDR_W'(NUM_CTX * 4096);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // Configuration state
  logic [NUM_SRC:1][PRIO_W-1:0]  prio_q, prio_d;
  logic [NUM_CTX-1:0][NUM_SRC:1] en_q, en_d;
  logic [NUM_CTX-1:0][PRIO_W-1:0] thr_q, thr_d;
  logic [31:0] rdata_q, rdata_d;

  // Address decode
  acc_sel_e           sel;
  logic [ADDR_W-1:0]  en_off, pg_off;
  logic [ID_W-1:0]    prio_idx;
  logic [CTX_W-1:0]   acc_ctx;
  logic               claim_rd, done_wr;

  always_comb begin
    en_off   = bus_addr - EN_BASE;
    pg_off   = bus_addr - PAGE_BASE;
    prio_idx = bus_addr[ID_W+1:2];
    sel      = SEL_NONE;
    acc_ctx  = pg_off[12 +: CTX_W];
    if (bus_addr < PRIO_SPAN) begin
      sel = SEL_PRIO;
    end else if ((en_off < EN_SPAN) && (en_off[6:2] == 5'd0)) begin
      sel     = SEL_EN;
      acc_ctx = en_off[7 +: CTX_W];
    end else if (pg_off < PG_SPAN) begin
      if (pg_off[11:2] == THR_WORD)        sel = SEL_THR;
      else if (pg_off[11:2] == CLAIM_WORD) sel = SEL_CLAIM;
    end
  end

  assign claim_rd = bus_ren && (sel == SEL_CLAIM);
  assign done_wr  = bus_wen && (sel == SEL_CLAIM);

  // Gateways and per-context arbitration
  logic [NUM_SRC:1]             pend_q, claimed_q, take, done;
  logic [NUM_CTX-1:0]           ctx_req;
  logic [NUM_CTX-1:0][ID_W-1:0] ctx_win;
  logic                         sel_req;
  logic [ID_W-1:0]              sel_win;

  genvar gs, gc;
  generate
    for (gs = 1; gs <= NUM_SRC; gs++) begin : g_src
      eic_gateway #(.EDGE(EDGE_MASK[gs])) u_gw (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .src     (src_i[gs]),
        .take    (take[gs]),
        .done    (done[gs]),
        .pend    (pend_q[gs]),
        .claimed (claimed_q[gs])
      );
    end
    for (gc = 0; gc < NUM_CTX; gc++) begin : g_ctx
      eic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
        .pend   (pend_q),
        .en     (en_q[gc]),
        .prio   (prio_q),
        .thr    (thr_q[gc]),
        .req    (ctx_req[gc]),
        .win_id (ctx_win[gc])
      );
    end
  endgenerate

  assign irq_o = ctx_req;

  always_comb begin
    sel_req = 1'b0;
    sel_win = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      if (acc_ctx == CTX_W'(c)) begin
        sel_req = ctx_req[c];
        sel_win = ctx_win[c];
      end
    end
  end

  // Claim and completion strobes per source
  always_comb begin
    take = '0;
    done = '0;
    for (int n = 1; n <= NUM_SRC; n++) begin
      take[n] = claim_rd && sel_req && (sel_win == ID_W'(n));
      for (int c = 0; c < NUM_CTX; c++) begin
        if (done_wr && (acc_ctx == CTX_W'(c)) && en_q[c][n] &&
            (bus_wdata == 32'(n)))
          done[n] = 1'b1;
      end
    end
  end

  // Register writes
  always_comb begin
    prio_d = prio_q;
    en_d   = en_q;
    thr_d  = thr_q;
    if (bus_wen) begin
      for (int n = 1; n <= NUM_SRC; n++)
        if ((sel == SEL_PRIO) && (prio_idx == ID_W'(n)))
          prio_d[n] = bus_wdata[PRIO_W-1:0];
      for (int c = 0; c < NUM_CTX; c++) begin
        if (acc_ctx == CTX_W'(c)) begin
          if (sel == SEL_EN)  en_d[c]  = bus_wdata[NUM_SRC:1];
          if (sel == SEL_THR) thr_d[c] = bus_wdata[PRIO_W-1:0];
        end
      end
    end
  end

  // Read data
  always_comb begin
    rdata_d = '0;
    case (sel)
      SEL_PRIO: begin
        for (int n = 1; n <= NUM_SRC; n++)
          if (prio_idx == ID_W'(n)) rdata_d[PRIO_W-1:0] = prio_q[n];
      end
      SEL_EN: begin
        for (int c = 0; c < NUM_CTX; c++)
          if (acc_ctx == CTX_W'(c))
            for (int n = 1; n <= NUM_SRC; n++) rdata_d[n] = en_q[c][n];
      end
      SEL_THR: begin
        for (int c = 0; c < NUM_CTX; c++)
          if (acc_ctx == CTX_W'(c)) rdata_d[PRIO_W-1:0] = thr_q[c];
      end
      SEL_CLAIM: begin
        if (sel_req) rdata_d[ID_W-1:0] = sel_win;
      end
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      prio_q  <= '0;
      en_q    <= '0;
      thr_q   <= '0;
      rdata_q <= '0;
    end else begin
      prio_q <= prio_d;
      en_q   <= en_d;
      thr_q  <= thr_d;
      if (bus_ren) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int CTX_W   = 1,
  localparam int ID_W   = $clog2(NUM_SRC + 1)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_CTX-1:0]            irq,
  input logic [NUM_SRC:1]              pend,
  input logic [NUM_SRC:1]              claimed,
  input logic [NUM_SRC:1]              done,
  input logic [NUM_CTX-1:0][PRIO_W-1:0] thr,
  input logic                          claim_rd,
  input logic [CTX_W-1:0]              acc_ctx,
  input logic [31:0]                   rdata
);
  logic [NUM_SRC:0] cl_ext, pend_ext;
  logic [ID_W-1:0]  rid;
  assign cl_ext   = {claimed, 1'b0};
  assign pend_ext = {pend, 1'b0};
  assign rid      = rdata[ID_W-1:0];

  genvar c, n;
  generate
    for (c = 0; c < NUM_CTX; c++) begin : g_c
      assert_full_thr_masks_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (thr[c] == '1) |-> !irq[c]);

      assert_empty_claim_zero_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (claim_rd && (acc_ctx == CTX_W'(c)) && !irq[c]) |=> (rdata == 32'd0));

      assert_claim_marks_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (claim_rd && (acc_ctx == CTX_W'(c)) && irq[c])
          |=> ((rid != '0) && cl_ext[rid] && !pend_ext[rid]));
    end
    for (n = 1; n <= NUM_SRC; n++) begin : g_n
      assert_pend_claim_excl_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        claimed[n] |-> !pend[n]);

      assert_claim_held_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (claimed[n] && !done[n]) |=> claimed[n]);
    end
  endgenerate
endmodule

bind ext_irq_ctrl eic_checker #(
  .NUM_SRC (NUM_SRC),
  .NUM_CTX (NUM_CTX),
  .PRIO_W  (PRIO_W),
  .CTX_W   (CTX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .irq      (irq_o),
  .pend     (pend_q),
  .claimed  (claimed_q),
  .done     (done),
  .thr      (thr_q),
  .claim_rd (claim_rd),
  .acc_ctx  (acc_ctx),
  .rdata    (bus_rdata)
);

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
  logic        clk;
  logic        rst_n;
  logic [21:0] bus_addr;
  logic        bus_wen;
  logic [31:0] bus_wdata;
  logic        bus_ren;
  logic [31:0] bus_rdata;
  logic [31:1] src;
  logic [1:0]  irq;

  int nchk  = 0;
  int nfail = 0;

  ext_irq_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .bus_ren   (bus_ren),
    .bus_rdata (bus_rdata),
    .src_i     (src),
    .irq_o     (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [21:0] a_prio(input int n);
    return 22'(4 * n);
  endfunction
  function automatic logic [21:0] a_en(input int c);
    return 22'h2000 + 22'(c * 'h80);
  endfunction
  function automatic logic [21:0] a_thr(input int c);
    return 22'h200000 + 22'(c * 'h1000);
  endfunction
  function automatic logic [21:0] a_clm(input int c);
    return 22'h200004 + 22'(c * 'h1000);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(input logic [21:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [21:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_ren = 1'b1;
    @(negedge clk);
    bus_ren = 1'b0;
    d = bus_rdata;
  endtask

  task automatic drive(input int n, input logic v);
    @(negedge clk);
    src[n] = v;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq after reset", 32'(irq), 32'd0);
    rd(a_prio(1), d);  chk("R1 prio1 reset", d, 32'd0);
    rd(a_en(0), d);    chk("R1 enable ctx0 reset", d, 32'd0);
    rd(a_thr(1), d);   chk("R1 threshold ctx1 reset", d, 32'd0);
    rd(a_clm(0), d);   chk("R1 claim after reset", d, 32'd0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(a_prio(5), 32'hFFFF_FFFF);
    rd(a_prio(5), d);  chk("R2 prio masked to 3 bits", d, 32'd7);
    wr(a_prio(0), 32'd7);
    rd(a_prio(0), d);  chk("R2 source 0 prio stays 0", d, 32'd0);
    wr(a_prio(5), 32'd0);
    wr(a_en(1), 32'hFFFF_FFFF);
    rd(a_en(1), d);    chk("R3 enable bit0 reads 0", d, 32'hFFFF_FFFE);
    rd(a_en(0), d);    chk("R3 ctx0 enable untouched", d, 32'd0);
    wr(a_en(1), 32'd0);
    wr(a_thr(0), 32'd5);
    rd(a_thr(0), d);   chk("R4 threshold ctx0", d, 32'd5);
    rd(a_thr(1), d);   chk("R4 threshold ctx1 separate", d, 32'd0);
    wr(a_thr(0), 32'd0);
  endtask

  task automatic t_threshold();
    logic [31:0] d;
    wr(a_prio(3), 32'd4);
    wr(a_en(0), 32'h8);
    wr(a_thr(0), 32'd4);
    drive(3, 1'b1); idle(1);
    chk("R5 prio equal threshold blocked", 32'(irq[0]), 32'd0);
    wr(a_thr(0), 32'd3);
    chk("R5 prio above threshold raises", 32'(irq[0]), 32'd1);
    wr(a_thr(0), 32'd7);
    chk("R5 threshold 7 masks", 32'(irq[0]), 32'd0);
    chk("R5 ctx1 not enabled", 32'(irq[1]), 32'd0);
    wr(a_en(1), 32'h8);
    chk("R3 ctx1 enable raises", 32'(irq[1]), 32'd1);
    wr(a_thr(0), 32'd0);
    rd(a_clm(1), d);   chk("R4 claim via ctx1", d, 32'd3);
    chk("R7 both lines drop after claim", 32'(irq), 32'd0);
    drive(3, 1'b0);
    wr(a_clm(1), 32'd3); idle(2);
    chk("R8 released level low stays idle", 32'(irq), 32'd0);
    wr(a_en(0), 32'd0); wr(a_en(1), 32'd0); wr(a_prio(3), 32'd0);
  endtask

  task automatic t_arbitrate();
    logic [31:0] d;
    wr(a_prio(2), 32'd3); wr(a_prio(6), 32'd5); wr(a_prio(9), 32'd5);
    wr(a_en(0), 32'h244);
    drive(2, 1'b1); src[6] = 1'b1; src[9] = 1'b1;
    idle(1);
    chk("R5 request with three sources", 32'(irq[0]), 32'd1);
    rd(a_clm(0), d);   chk("R6 highest priority, lowest ID", d, 32'd6);
    rd(a_clm(0), d);   chk("R6 next tie member", d, 32'd9);
    rd(a_clm(0), d);   chk("R6 lower priority last", d, 32'd2);
    rd(a_clm(0), d);   chk("R7 claimed sources not offered", d, 32'd0);
    chk("R7 no request while all claimed", 32'(irq[0]), 32'd0);
    drive(2, 1'b0); src[6] = 1'b0; src[9] = 1'b0;
    wr(a_clm(0), 32'd6); wr(a_clm(0), 32'd9); wr(a_clm(0), 32'd2);
    idle(2);
    chk("R8 all released, inputs low", 32'(irq[0]), 32'd0);
    wr(a_en(0), 32'd0);
    wr(a_prio(2), 32'd0); wr(a_prio(6), 32'd0); wr(a_prio(9), 32'd0);
  endtask

  task automatic t_completion();
    logic [31:0] d;
    wr(a_prio(4), 32'd2);
    wr(a_en(0), 32'h10);
    drive(4, 1'b1); idle(1);
    chk("R10 level input pends", 32'(irq[0]), 32'd1);
    rd(a_clm(0), d);   chk("R6 claim level source", d, 32'd4);
    chk("R7 claimed level blocked", 32'(irq[0]), 32'd0);
    wr(a_clm(1), 32'd4); idle(2);
    chk("R9 completion from non-enabled ctx ignored", 32'(irq[0]), 32'd0);
    rd(a_clm(0), d);   chk("R9 still claimed", d, 32'd0);
    wr(a_clm(0), 32'd5); idle(2);
    rd(a_clm(0), d);   chk("R9 unclaimed ID ignored", d, 32'd0);
    wr(a_clm(0), 32'd4); idle(1);
    chk("R8 level still high re-pends", 32'(irq[0]), 32'd1);
    rd(a_clm(0), d);   chk("R8 reclaim after completion", d, 32'd4);
    drive(4, 1'b0);
    wr(a_clm(0), 32'd4); idle(2);
    chk("R10 low level after completion", 32'(irq[0]), 32'd0);
    drive(4, 1'b1); drive(4, 1'b0); idle(1);
    chk("R10 pending latched after input falls", 32'(irq[0]), 32'd1);
    rd(a_clm(0), d);   chk("R10 latched claim", d, 32'd4);
    wr(a_clm(0), 32'd4); idle(2);
    chk("R10 idle after latched completion", 32'(irq[0]), 32'd0);
    wr(a_en(0), 32'd0); wr(a_prio(4), 32'd0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(a_prio(20), 32'd6);
    wr(a_en(1), 32'h0010_0000);
    drive(20, 1'b1); drive(20, 1'b0); idle(1);
    chk("R11 rising edge pends", 32'(irq[1]), 32'd1);
    chk("R11 ctx0 unaffected", 32'(irq[0]), 32'd0);
    drive(20, 1'b1); drive(20, 1'b0);
    rd(a_clm(1), d);   chk("R11 claim edge source", d, 32'd20);
    wr(a_clm(1), 32'd20); idle(2);
    chk("R11 edge while pending dropped", 32'(irq[1]), 32'd0);
    drive(20, 1'b1); drive(20, 1'b0); idle(1);
    rd(a_clm(1), d);   chk("R11 second claim", d, 32'd20);
    drive(20, 1'b1); drive(20, 1'b0);
    wr(a_clm(1), 32'd20); idle(2);
    chk("R11 edge while claimed dropped", 32'(irq[1]), 32'd0);
    rd(a_clm(1), d);   chk("R11 nothing to claim", d, 32'd0);
    drive(20, 1'b1); idle(1);
    rd(a_clm(1), d);   chk("R11 held input claims once", d, 32'd20);
    wr(a_clm(1), 32'd20); idle(3);
    chk("R11 held high no new request", 32'(irq[1]), 32'd0);
    drive(20, 1'b0);
    wr(a_en(1), 32'd0); wr(a_prio(20), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bus_addr = '0; bus_wen = 1'b0; bus_wdata = '0; bus_ren = 1'b0;
    src = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_regmap();
    t_threshold();
    t_arbitrate();
    t_completion();
    t_edge();
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule